// File: doc/BRIEF.md
# Video Timing Integrity Monitor

This block sits on a parallel video timing stream in the pixel clock domain. It watches two signals, a data-enable and a vertical sync. It measures how long each data-enable active period lasts and how long each vertical-sync pulse lasts. It then compares each new length with the previous length of the same signal. When the comparisons show that the timing has broken, it pulls a single status output low. It raises the output again once the timing has stayed steady for a full frame.

The two signals follow different persistence rules. One data-enable period of the wrong length is a fault at once. A vertical-sync length must differ on two consecutive pulses before it counts as a fault. When the self-test enable is high, the status output instead shows an external self-test error flag. An active-low wake input acts as power-down: while it is low, every register is held in reset and the output enable is low.

The fault logic is a three-state machine. State `ST_GOOD` means the timing is healthy and the output is high. State `ST_FAULT` means a fault has been declared. State `ST_WATCH` means a clean vertical-sync end has been seen after a fault, and the monitor is waiting for one more clean frame. It has five transitions:
- `GOOD->FAULT`: a data-enable mismatch, or a second vertical-sync mismatch in a row.
- `FAULT->WATCH`: a vertical-sync end with no mismatch on that clock.
- `WATCH->GOOD`: the next vertical-sync end with no mismatch.
- `WATCH->FAULT`: any mismatch of either signal while watching.
- `any->GOOD`: a clear, caused by self-test being active or the self-test input changing.

Top module: `vtm_monitor`

## Requirements
- R1: While `awake` is low, `ok_oe` is 0 and all internal state is reset. After `awake` returns high, `ok_oe` is 1, `ok_out` is 1, and the next measurement of each signal only loads a reference.
- R2: In normal mode (`selftest_en`=0), `ok_out`=1 means no timing fault and `ok_out`=0 means a timing fault.
- R3: The data-enable length is the number of rising pixel-clock edges at which `de_in` is sampled high. If one length differs from the previous one, `ok_out` goes to 0 right after the edge where `de_in` is first sampled low.
- R4: A single vertical-sync length mismatch leaves `ok_out` unchanged. A mismatch on two consecutive vertical-sync measurements drives `ok_out` to 0. A matching measurement in between resets this count.
- R5: The first measurement of each signal after reset or a clear never produces a mismatch.
- R6: After a mismatch, the new length becomes the reference, so a repeated new length does not mismatch again.
- R7: After a fault, `ok_out` stays 0 until two vertical-sync ends in a row pass with no mismatch of either signal at or between them. It returns to 1 right after the second of those ends.
- R8: The data-enable counter is DE_W bits and the vertical-sync counter is VS_W bits. Each saturates at 2^W-1 instead of wrapping, and a saturated length is compared like any other.
- R9: While `selftest_en`=1, `ok_out` equals the inverse of `selftest_err`, combinationally.
- R10: While `selftest_en` is high, and on the edge after it changes, the timing state is cleared: the output goes back to good, both references are dropped, and the vertical-sync streak resets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| awake | input | 1 | Active-low power-down: 0 resets everything and disables the output |
| de_in | input | 1 | Data-enable |
| vs_in | input | 1 | Vertical sync, active high |
| selftest_en | input | 1 | Selects self-test reporting |
| selftest_err | input | 1 | External self-test error flag |
| ok_out | output | 1 | Status: 1 means pass, 0 means fault |
| ok_oe | output | 1 | Output enable for the status pin |

## Verification
A measurement ends at the first rising edge where its signal is sampled low. The resulting state change, and so `ok_out`, is visible right after that edge. The self-test selection and the wake input reach `ok_out` and `ok_oe` without any register. The bench changes all inputs on falling edges. It checks the state-driven results on the falling edge that follows the edge that ends the measurement. It checks the combinational paths a short delay after the input changes.

// File: rtl/vtm_pkg.sv
package vtm_pkg;
    typedef enum logic [1:0] {
        ST_GOOD  = 2'd0,
        ST_FAULT = 2'd1,
        ST_WATCH = 2'd2
    } vtm_state_e;
endpackage

// File: rtl/vtm_len_meter.sv
// Measures how long a pulse stays high, compares it with the previous length.
module vtm_len_meter #(
    parameter int W = 16
) (
    input  logic clk,
    input  logic awake,
    input  logic clr,
    input  logic sig,
    output logic done,
    output logic miss
);
    localparam logic [W-1:0] TOP = '1;
    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

    logic         sig_q;
    logic         ref_vld;
    logic [W-1:0] cnt;
    logic [W-1:0] ref_len;

    always_ff @(posedge clk or negedge awake) begin
        if (!awake) begin
            sig_q   <= 1'b0;
            ref_vld <= 1'b0;
            cnt     <= '0;
            ref_len <= '0;
        end else if (clr) begin
            sig_q   <= 1'b0;
            ref_vld <= 1'b0;
            cnt     <= '0;
            ref_len <= '0;
        end else begin
            sig_q <= sig;
            if (sig) begin
                if (!sig_q)          cnt <= ONE;
                else if (cnt != TOP) cnt <= cnt + ONE;
            end
            if (done) begin
                ref_len <= cnt;
                ref_vld <= 1'b1;
            end
        end
    end

    always_comb begin
        done = sig_q & ~sig;
        miss = done & ref_vld & (cnt != ref_len);
    end

    // R8: a counter at its top value stays there while the pulse continues
    a_r8_hold_at_top: assert property (@(posedge clk) disable iff (!awake)
        (sig && sig_q && cnt == TOP && !clr) |=> cnt == TOP);
endmodule

// File: rtl/vtm_fault_fsm.sv
// Persistence rules and recovery sequencing for timing faults.
module vtm_fault_fsm
    import vtm_pkg::*;
(
    input  logic clk,
    input  logic awake,
    input  logic clr,
    input  logic de_miss,
    input  logic vs_done,
    input  logic vs_miss,
    output logic timing_ok
);
    vtm_state_e state, state_nx;
    logic       streak;
    logic       vs_fault;

    assign vs_fault = vs_miss & streak;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_GOOD:  if (de_miss || vs_fault) state_nx = ST_FAULT;
            ST_FAULT: if (de_miss || vs_miss)  state_nx = ST_FAULT;
                      else if (vs_done)        state_nx = ST_WATCH;
            ST_WATCH: if (de_miss || vs_miss)  state_nx = ST_FAULT;
                      else if (vs_done)        state_nx = ST_GOOD;
            default:                           state_nx = ST_GOOD;
        endcase
        if (clr) state_nx = ST_GOOD;
    end

    always_ff @(posedge clk or negedge awake) begin
        if (!awake) state <= ST_GOOD;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge awake) begin
        if (!awake)       streak <= 1'b0;
        else if (clr)     streak <= 1'b0;
        else if (vs_done) streak <= vs_miss;
    end

    always_comb begin
        timing_ok = (state == ST_GOOD);
    end

    // R3: one data-enable mismatch faults on the next cycle
    a_r3_de_trips: assert property (@(posedge clk) disable iff (!awake)
        (de_miss && !clr) |=> state == ST_FAULT);
    // R4: a lone vertical-sync mismatch is tolerated
    a_r4_lone_vs: assert property (@(posedge clk) disable iff (!awake)
        (state == ST_GOOD && vs_miss && !streak && !de_miss && !clr) |=> state == ST_GOOD);
    // R4: a second mismatch in a row faults
    a_r4_pair_vs: assert property (@(posedge clk) disable iff (!awake)
        (vs_miss && streak && !clr) |=> state == ST_FAULT);
    // R7: recovery completes only at a vertical-sync end
    a_r7_watch_waits: assert property (@(posedge clk) disable iff (!awake)
        (state == ST_WATCH && !vs_done && !clr) |=> state != ST_GOOD);
    // R10: a clear restores the good state and drops the streak
    a_r10_clear: assert property (@(posedge clk) disable iff (!awake)
        clr |=> (state == ST_GOOD && !streak));
endmodule

// File: rtl/vtm_monitor.sv
module vtm_monitor
    import vtm_pkg::*;
#(
    parameter int DE_W = 16,
    parameter int VS_W = 24
) (
    input  logic clk,
    input  logic awake,
    input  logic de_in,
    input  logic vs_in,
    input  logic selftest_en,
    input  logic selftest_err,
    output logic ok_out,
    output logic ok_oe
);
    logic st_q;
    logic clr;
    logic de_done, de_miss;
    logic vs_done, vs_miss;
    logic timing_ok;

    always_ff @(posedge clk or negedge awake) begin
        if (!awake) st_q <= 1'b0;
        else        st_q <= selftest_en;
    end

    assign clr = selftest_en | (st_q ^ selftest_en);

    vtm_len_meter #(.W(DE_W)) u_de (
        .clk(clk), .awake(awake), .clr(clr), .sig(de_in),
        .done(de_done), .miss(de_miss)
    );

    vtm_len_meter #(.W(VS_W)) u_vs (
        .clk(clk), .awake(awake), .clr(clr), .sig(vs_in),
        .done(vs_done), .miss(vs_miss)
    );

    vtm_fault_fsm u_fsm (
        .clk(clk), .awake(awake), .clr(clr),
        .de_miss(de_miss), .vs_done(vs_done), .vs_miss(vs_miss),
        .timing_ok(timing_ok)
    );

    always_comb begin
        ok_oe  = awake;
        ok_out = selftest_en ? ~selftest_err : timing_ok;
    end

    logic unused_de_done;
    assign unused_de_done = de_done;

    // R9: self-test mode reports the inverted error flag
    always_comb begin
        if (awake && selftest_en)
            a_r9_selftest_mux: assert (ok_out == !selftest_err);
    end
endmodule

// File: tb/vtm_monitor_test.sv
`timescale 1ns/1ps
module vtm_monitor_test;
    logic clk = 1'b0;
    logic awake = 1'b0;
    logic de_in = 1'b0;
    logic vs_in = 1'b0;
    logic selftest_en = 1'b0;
    logic selftest_err = 1'b0;
    logic ok_out, ok_oe;
    int   total = 0;
    int   bad = 0;
    bit   finished = 1'b0;

    always #2 clk = ~clk;

    vtm_monitor #(.DE_W(6), .VS_W(8)) uut (
        .clk(clk), .awake(awake), .de_in(de_in), .vs_in(vs_in),
        .selftest_en(selftest_en), .selftest_err(selftest_err),
        .ok_out(ok_out), .ok_oe(ok_oe)
    );

    task automatic chk(input logic got, input logic exp, input string what);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got=%b expected=%b", what, got, exp);
        end
    endtask

    task automatic de_pulse(input int n);
        de_in = 1'b1;
        repeat (n) @(negedge clk);
        de_in = 1'b0;
        @(negedge clk);
    endtask

    task automatic vs_pulse(input int n);
        vs_in = 1'b1;
        repeat (n) @(negedge clk);
        vs_in = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset;
        awake = 1'b0;
        repeat (3) @(negedge clk);
        chk(ok_oe, 1'b0, "R1 oe low in power-down");
        awake = 1'b1;
        @(negedge clk);
        chk(ok_oe, 1'b1, "R1 oe high when awake");
        chk(ok_out, 1'b1, "R2 pass after wake");
    endtask

    task automatic t_first_and_de;
        vs_pulse(4);
        chk(ok_out, 1'b1, "R5 first vs loads only");
        de_pulse(10);
        chk(ok_out, 1'b1, "R5 first de loads only");
        de_pulse(10);
        chk(ok_out, 1'b1, "R3 matching de stays pass");
        de_pulse(11);
        chk(ok_out, 1'b0, "R3 single de mismatch faults");
    endtask

    task automatic t_recover;
        de_pulse(11);
        chk(ok_out, 1'b0, "R6 new de ref, fault held");
        vs_pulse(4);
        chk(ok_out, 1'b0, "R7 first clean vs end still fault");
        de_pulse(11);
        chk(ok_out, 1'b0, "R7 mid frame still fault");
        vs_pulse(4);
        chk(ok_out, 1'b1, "R7 clean frame restores pass");
    endtask

    task automatic t_vs_rules;
        vs_pulse(5);
        chk(ok_out, 1'b1, "R4 lone vs mismatch tolerated");
        vs_pulse(5);
        chk(ok_out, 1'b1, "R6 vs ref replaced");
        vs_pulse(6);
        chk(ok_out, 1'b1, "R4 first of pair tolerated");
        vs_pulse(5);
        chk(ok_out, 1'b0, "R4 second consecutive vs mismatch faults");
        vs_pulse(5);
        vs_pulse(5);
        chk(ok_out, 1'b1, "R7 two clean vs ends restore");
        vs_pulse(6);
        vs_pulse(6);
        vs_pulse(7);
        chk(ok_out, 1'b1, "R4 match between misses resets streak");
    endtask

    task automatic t_saturate;
        awake = 1'b0;
        @(negedge clk);
        awake = 1'b1;
        @(negedge clk);
        de_pulse(70);
        chk(ok_out, 1'b1, "R1 refs dropped by power-down");
        de_pulse(90);
        chk(ok_out, 1'b1, "R8 both saturate to 63, match");
        de_pulse(63);
        chk(ok_out, 1'b1, "R8 exact top value matches");
        de_pulse(62);
        chk(ok_out, 1'b0, "R8 saturated ref compared normally");
    endtask

    task automatic t_selftest;
        selftest_en = 1'b1;
        selftest_err = 1'b0;
        #1;
        chk(ok_out, 1'b1, "R9 selftest no error");
        selftest_err = 1'b1;
        #1;
        chk(ok_out, 1'b0, "R9 selftest error");
        @(negedge clk);
        selftest_err = 1'b0;
        selftest_en = 1'b0;
        @(negedge clk);
        chk(ok_out, 1'b1, "R10 fault cleared by selftest switch");
        de_pulse(20);
        chk(ok_out, 1'b1, "R10 fresh de reference");
        de_pulse(20);
        chk(ok_out, 1'b1, "R10 matching after fresh ref");
    endtask

    initial begin
        repeat (2) @(negedge clk);
        t_reset();
        t_first_and_de();
        t_recover();
        t_vs_rules();
        t_saturate();
        t_selftest();
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: got=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule